// File: doc/BRIEF.md
# Sub-word Cascaded Magnitude Comparator

This block compares two unsigned operands of a parameterised width (4, 8 or 16 bits) and raises exactly one of three flags: first operand larger, first operand smaller, or both equal. Each operand is cut into short fields of two or three bits, using a fixed cut for each width. Every field pair is compared on its own and gives a local "larger" and "smaller" flag. A chain of merge cells then walks from the most significant field down to the least significant one. At each step a cell keeps the upper field's verdict when that verdict is decisive, and otherwise takes the verdict of the field below. Equality comes from a separate unit that looks at the two merged flags.

Every AND and OR in the datapath is a three-input majority function with one input tied to a constant, plus inverters. This keeps the netlist in a form that maps straight onto majority-logic fabrics. A parameter chooses between a purely combinational result and one output register. The register adds one cycle of latency and has a synchronous active-high reset. Widths other than 4, 8 and 16 stop elaboration with an error.

Field cuts, most significant field first: width 4 uses [3:2] and [1:0]. Width 8 uses [7:5], [4:2] and [1:0]. Width 16 uses [15:14], [13:11], [10:8], [7:5], [4:2] and [1:0].

Top module: `mag_cmp_cascade`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, with both operands read as unsigned.
- R2: `lt_o` is 1 exactly when `a_i` is less than `b_i`, with both operands read as unsigned.
- R3: `eq_o` is 1 exactly when `a_i` equals `b_i`.
- R4: Outside reset, exactly one of `gt_o`, `lt_o`, `eq_o` is 1.
- R5: With REG_OUT=1 (the default), the flags show the operands sampled at the previous rising clock edge. An operand change between edges does not alter the flags until the next edge.
- R6: With REG_OUT=1, a high `rst` at a rising edge clears all three flags to 0, whatever the operands are.
- R7: A more significant field that differs decides the result, whatever the less significant fields hold. A single-bit difference at any bit position, inside a field or at the edge between two fields, gives the flag that belongs to the operand holding the 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| gt_o | output | 1 | First operand greater than second |
| lt_o | output | 1 | First operand less than second |
| eq_o | output | 1 | Operands equal |

## Verification
The hardest situation to reach from the ports is the 16-bit case where fields disagree: an upper field favours one operand while lower fields favour the other, or a single differing bit sits right at the edge between two fields. Uniform random operands rarely produce a difference confined to one field, and almost never produce equality. The 16-bit stimulus therefore rotates through several patterns: an exact copy of the operand, a single flipped bit that sweeps every position, all-zero and all-one pairs, and plain random values. At the same time the 4-bit and 8-bit instances are driven through every operand pair.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // Three-input majority: the only two-input-capable primitive used.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic m_and(input logic x, input logic y);
    return maj3(x, y, 1'b0);
  endfunction

  function automatic logic m_or(input logic x, input logic y);
    return maj3(x, y, 1'b1);
  endfunction

  function automatic logic m_inv(input logic x);
    return ~x;
  endfunction

  // Number of fields for a supported width.
  function automatic int seg_count(input int width);
    return (width == 4) ? 2 : (width == 8) ? 3 : 6;
  endfunction

  // Lowest bit of field s (field 0 is least significant, 2 bits wide).
  function automatic int seg_lo(input int s);
    return (s == 0) ? 0 : 2 + 3 * (s - 1);
  endfunction

  // Width of field s: 2 for the lowest, 3 above, trimmed at the top.
  function automatic int seg_w(input int width, input int s);
    int rem;
    rem = width - seg_lo(s);
    if (s == 0) return 2;
    return (rem < 3) ? rem : 3;
  endfunction

endpackage

// File: rtl/mc_merge_cell.sv
module mc_merge_cell
  import mag_cmp_pkg::*;
(
  input  logic hi_gt,
  input  logic hi_lt,
  input  logic lo_gt,
  input  logic lo_lt,
  output logic gt,
  output logic lt
);
  // Upper verdict wins when decisive; otherwise the lower one passes.
  always_comb begin
    gt = m_or(hi_gt, m_and(m_inv(hi_lt), lo_gt));
    lt = m_or(hi_lt, m_and(m_inv(hi_gt), lo_lt));
  end
endmodule

// File: rtl/mc_subword.sv
module mc_subword
  import mag_cmp_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         lt
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    logic bgt, blt, cgt, clt;
    always_comb begin
      bgt = m_and(a[j], m_inv(b[j]));
      blt = m_and(m_inv(a[j]), b[j]);
    end
    if (j == W - 1) begin : g_top
      assign cgt = bgt;
      assign clt = blt;
    end else begin : g_mid
      mc_merge_cell u_m (
        .hi_gt(g_bit[j+1].cgt), .hi_lt(g_bit[j+1].clt),
        .lo_gt(bgt), .lo_lt(blt), .gt(cgt), .lt(clt)
      );
    end
  end

  assign gt = g_bit[0].cgt;
  assign lt = g_bit[0].clt;
endmodule

// File: rtl/mc_equal.sv
module mc_equal
  import mag_cmp_pkg::*;
(
  input  logic gt,
  input  logic lt,
  output logic eq
);
  always_comb eq = m_inv(m_or(gt, lt));
endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam int NSEG = seg_count(WIDTH);

  if (!(WIDTH == 4 || WIDTH == 8 || WIDTH == 16)) begin : g_bad_width
    $error("mag_cmp_cascade: WIDTH must be 4, 8 or 16");
  end

  // Field comparators and the merge chain, top field first.
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = seg_lo(s);
    localparam int SW = seg_w(WIDTH, s);
    logic sgt, slt, cgt, clt;

    mc_subword #(.W(SW)) u_sw (
      .a(a_i[LO +: SW]), .b(b_i[LO +: SW]), .gt(sgt), .lt(slt)
    );

    if (s == NSEG - 1) begin : g_head
      assign cgt = sgt;
      assign clt = slt;
    end else begin : g_link
      mc_merge_cell u_mc (
        .hi_gt(g_seg[s+1].cgt), .hi_lt(g_seg[s+1].clt),
        .lo_gt(sgt), .lo_lt(slt), .gt(cgt), .lt(clt)
      );
    end
  end

  logic c_gt, c_lt, c_eq;
  assign c_gt = g_seg[0].cgt;
  assign c_lt = g_seg[0].clt;

  mc_equal u_eq (.gt(c_gt), .lt(c_lt), .eq(c_eq));

  if (REG_OUT) begin : g_reg
    logic r_gt, r_lt, r_eq;
    always_ff @(posedge clk) begin
      if (rst) begin
        r_gt <= 1'b0;
        r_lt <= 1'b0;
        r_eq <= 1'b0;
      end else begin
        r_gt <= c_gt;
        r_lt <= c_lt;
        r_eq <= c_eq;
      end
    end
    assign gt_o = r_gt;
    assign lt_o = r_lt;
    assign eq_o = r_eq;
  end else begin : g_comb
    assign gt_o = c_gt;
    assign lt_o = c_lt;
    assign eq_o = c_eq;
  end
endmodule

// File: rtl/mag_cmp_cascade_chk.sv
module mag_cmp_cascade_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             gt_o,
  input logic             lt_o,
  input logic             eq_o
);
  if (REG_OUT) begin : g_reg_chk
    assert_gt_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (gt_o == $past(a_i > b_i)));
    assert_lt_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (lt_o == $past(a_i < b_i)));
    assert_eq_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (eq_o == $past(a_i == b_i)));
    assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $onehot({gt_o, lt_o, eq_o}));
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(a_i) && $stable(b_i)) |=>
        $stable({gt_o, lt_o, eq_o}));
    assert_clear_R6: assert property (@(posedge clk)
      rst |=> ({gt_o, lt_o, eq_o} == 3'b000));
  end else begin : g_comb_chk
    assert_gt_R1: assert property (@(posedge clk) disable iff (rst)
      gt_o == (a_i > b_i));
    assert_lt_R2: assert property (@(posedge clk) disable iff (rst)
      lt_o == (a_i < b_i));
    assert_eq_R3: assert property (@(posedge clk) disable iff (rst)
      eq_o == (a_i == b_i));
    assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot({gt_o, lt_o, eq_o}));
  end
endmodule

bind mag_cmp_cascade mag_cmp_cascade_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
  .gt_o(gt_o), .lt_o(lt_o), .eq_o(eq_o)
);

// File: tb/sim_mag_cmp_cascade.sv
module sim_mag_cmp_cascade;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] a16 = '0, b16 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic g16, l16, e16, g8, l8, e8, g4, l4, e4;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  mag_cmp_cascade #(.WIDTH(16)) u0 (.clk(clk), .rst(rst), .a_i(a16), .b_i(b16),
    .gt_o(g16), .lt_o(l16), .eq_o(e16));
  mag_cmp_cascade #(.WIDTH(8)) u1 (.clk(clk), .rst(rst), .a_i(a8), .b_i(b8),
    .gt_o(g8), .lt_o(l8), .eq_o(e8));
  mag_cmp_cascade #(.WIDTH(4)) u2 (.clk(clk), .rst(rst), .a_i(a4), .b_i(b4),
    .gt_o(g4), .lt_o(l4), .eq_o(e4));

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual gt/lt/eq=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ref16(input logic [15:0] a, input logic [15:0] b);
    return {a > b, a < b, a == b};
  endfunction
  function automatic logic [2:0] ref8(input logic [7:0] a, input logic [7:0] b);
    return {a > b, a < b, a == b};
  endfunction
  function automatic logic [2:0] ref4(input logic [3:0] a, input logic [3:0] b);
    return {a > b, a < b, a == b};
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " w16 R1 R2 R3 R4"}, {g16, l16, e16}, ref16(a16, b16));
    chk({tag, " w8 R1 R2 R3 R4"},  {g8, l8, e8},    ref8(a8, b8));
    chk({tag, " w4 R1 R2 R3 R4"},  {g4, l4, e4},    ref4(a4, b4));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still active expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    a16 = 16'hFFFF; b16 = 16'h0001; a8 = 8'h80; b8 = 8'h01; a4 = 4'h9; b4 = 4'h2;
    repeat (3) @(negedge clk);
    // R6: flags cleared under reset although operands differ
    chk("R6 reset w16", {g16, l16, e16}, 3'b000);
    chk("R6 reset w8",  {g8, l8, e8},    3'b000);
    chk("R6 reset w4",  {g4, l4, e4},    3'b000);
    rst = 1'b0;
    @(negedge clk);
    check_all("after reset");

    // R5: one cycle latency, new operands invisible before the next edge
    a16 = 16'h0100; b16 = 16'h00FF;
    @(negedge clk);
    chk("R5 settle", {g16, l16, e16}, 3'b100);
    a16 = 16'h0010; b16 = 16'h8000;
    #2;
    chk("R5 hold before edge", {g16, l16, e16}, 3'b100);
    @(negedge clk);
    chk("R5 after edge", {g16, l16, e16}, 3'b010);

    // R7: upper field decides against opposite lower fields
    a16 = 16'h4000; b16 = 16'h3FFF; @(negedge clk); check_all("R7 top field wins gt");
    a16 = 16'h07FF; b16 = 16'h0800; @(negedge clk); check_all("R7 field edge lt");
    a16 = 16'h0020; b16 = 16'h001F; @(negedge clk); check_all("R7 field edge gt");
    for (int k = 0; k < 16; k++) begin
      a16 = 16'h1234 | (16'h1 << k);
      b16 = a16 & ~(16'h1 << k);
      @(negedge clk);
      chk("R7 single bit a high", {g16, l16, e16}, 3'b100);
      a16 = 16'hA5A5 & ~(16'h1 << k);
      b16 = a16 | (16'h1 << k);
      @(negedge clk);
      chk("R7 single bit b high", {g16, l16, e16}, 3'b010);
    end

    // Exhaustive 8-bit and 4-bit, mixed 16-bit patterns (R1 R2 R3 R4)
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      a8 = i[7:0]; b8 = i[15:8];
      a4 = i[3:0]; b4 = i[11:8];
      case (i % 8)
        0: begin a16 = r; b16 = r; end
        1: begin a16 = r; b16 = r ^ (16'h1 << ((i / 8) % 16)); end
        2: begin a16 = (i[3]) ? 16'hFFFF : 16'h0000; b16 = (i[4]) ? 16'hFFFF : 16'h0000; end
        3: begin a16 = r; b16 = {r[15:8], 8'($urandom)}; end
        default: begin a16 = r; b16 = 16'($urandom); end
      endcase
      @(negedge clk);
      check_all("sweep");
    end

    // R6: reset mid-run clears, release resumes
    a16 = 16'h0002; b16 = 16'h0001; rst = 1'b1;
    @(negedge clk);
    chk("R6 mid-run reset", {g16, l16, e16}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {g16, l16, e16}, 3'b100);

    finish_run();
  end
endmodule